// File: doc/BRIEF.md
# Half-Cycle Fractional Clock Divider

This block produces a slower clock from a fast input clock at the fixed non-integer ratio of 20:3, for example 3.6864 MHz from 24.576 MHz. No PLL is involved. Each input period is split into two time slots, its high phase and its low phase. A ten-state one-hot sequencer steps once per input period, so one revolution covers twenty slots. Three of these slots are chosen, spaced 7, 7 and 6 half-cycles apart. The chosen slots are merged into one pulse train, and each pulse toggles a flip-flop whose output is the divided clock.

The output has period jitter because the pulse spacing is uneven. Its average frequency is exactly the input frequency times 3/20. The pulse train is also driven on a debug output, which lets the slot placement be seen directly. Slots are numbered from the first high phase after reset is released. Slot 2k is the high phase of sequencer state k, and slot 2k+1 is its low phase.

Top module: `halfphase_divider`

## Requirements
- R1: Over any run of 20·n input cycles that starts at release from reset, the divided clock shows exactly 3·n rising edges. The count includes the rise in slot 0, measured from the low level held during reset.
- R2: The sequencer has ten states, exactly one of them active, and advances one state per input period. The pulse pattern therefore recurs every 20 slots: the pulse output in slot s equals the pulse output in slot s-20.
- R3: The pulse output is high exactly in the slots whose number modulo 20 is 0, 7 or 14. These are the high phase of state 0, the low phase of state 3 and the high phase of state 7. It is low in every other slot.
- R4: Going forward in slot order, the gap between consecutive pulses is 7, then 7, then 6 half-cycles. A pulse in slot 14 mod 20 is followed 6 slots later, and any other pulse is followed 7 slots later.
- R5: The divided clock toggles once on every pulse and at no other time. In slot s its level is the parity of the number of pulses in slots 0 through s, starting from 0.
- R6: While reset is high, the divided clock is 0 from the moment reset rises. From the second rising input edge that samples reset high, the pulse output is also 0.
- R7: The first pulse after reset is released falls in the first high phase after release, which is slot 0. A reset in the middle of a revolution restarts the pattern from slot 0.
- R8: The divided clock pattern repeats every 20 input cycles (40 slots): its level in slot s equals its level in slot s-40.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Fast input clock; both of its phases are used as slots |
| rst | input | 1 | Active-high reset, sampled on the rising input edge; it also clears the output flip-flop directly |
| divClk | output | 1 | Divided clock at 3/20 of the input frequency |
| pulseDbg | output | 1 | Gated pulse train that toggles the output flip-flop |

## Verification
The hardest situation to reach is a reset that lands in the middle of a revolution. In that case a low-phase pulse or a half-built output cycle is already pending, and the next release must still begin cleanly at slot 0. The stimulus mixes full runs of 20 and 40 input cycles with randomly truncated runs, each ended by a reset of random length. Every release is therefore followed by a pattern that starts from an arbitrary earlier phase. The bench samples each high phase and each low phase separately, so it checks pulse placement and output level at half-cycle resolution.

// File: rtl/hpd_pkg.sv
`timescale 1ns/1ps
package hpd_pkg;

  // Number of sequencer states; one revolution spans twice as many slots.
  localparam int SEQ_LEN    = 10;
  localparam int SLOT_COUNT = 2 * SEQ_LEN;
  localparam int PICKS      = 3;

  // Chosen slots inside one revolution (even = high phase, odd = low phase).
  localparam int PICK_SLOT [PICKS] = '{0, 7, 14};

  typedef logic [SEQ_LEN-1:0] seqVec_t;

  // Strobes handed from control to datapath: which phase of the current
  // input period may pass a pulse.
  typedef struct packed {
    logic highSel;
    logic lowSel;
  } gateStrobe_t;

  // Build the per-state mask of picks that fall in the requested phase.
  function automatic seqVec_t phaseMask(input logic wantHigh);
    seqVec_t m;
    m = '0;
    for (int i = 0; i < PICKS; i++) begin
      if (((PICK_SLOT[i] % 2) == 0) == wantHigh) begin
        m[PICK_SLOT[i] / 2] = 1'b1;
      end
    end
    return m;
  endfunction

  localparam seqVec_t HI_MASK = phaseMask(1'b1);
  localparam seqVec_t LO_MASK = phaseMask(1'b0);

endpackage

// File: rtl/hpd_ctrl.sv
`timescale 1ns/1ps
module hpd_ctrl
  import hpd_pkg::*;
(
  input  logic        clkIn,
  input  logic        rst,
  output gateStrobe_t strobe,
  output seqVec_t     seqState,
  output logic        seqRun
);

  seqVec_t nxtState;
  logic    highSel;
  logic    lowSel;

  // Rotate once per input period once running; on the first edge after
  // release the sequencer holds state 0 so that its high phase is slot 0.
  always_comb begin
    nxtState = seqRun ? {seqState[SEQ_LEN-2:0], seqState[SEQ_LEN-1]} : seqState;
  end

  // Rising edge: advance the state and arm the low-phase gate for the
  // period that is just starting.
  always_ff @(posedge clkIn) begin
    if (rst) begin
      seqState <= SEQ_LEN'(1);
      seqRun   <= 1'b0;
      lowSel   <= 1'b0;
    end else begin
      seqState <= nxtState;
      seqRun   <= 1'b1;
      lowSel   <= |(nxtState & LO_MASK);
    end
  end

  // Falling edge: arm the high-phase gate for the coming period while the
  // clock is low, so the select never moves under a high clock.
  always_ff @(negedge clkIn) begin
    if (rst) begin
      highSel <= 1'b0;
    end else begin
      highSel <= |(nxtState & HI_MASK);
    end
  end

  assign strobe.highSel = highSel;
  assign strobe.lowSel  = lowSel;

endmodule

// File: rtl/hpd_datapath.sv
`timescale 1ns/1ps
module hpd_datapath
  import hpd_pkg::*;
(
  input  logic        clkIn,
  input  logic        rst,
  input  gateStrobe_t strobe,
  output logic        divClk,
  output logic        pulseDbg
);

  logic gatedPulse;
  logic divQ;

  // Behavioural clock gating. On silicon, a clock formed from logic like
  // this needs explicit timing constraints on the gate and the generated
  // clock; here each select only changes while its own phase is blocked.
  assign gatedPulse = (strobe.highSel & clkIn) | (strobe.lowSel & ~clkIn);

  always_ff @(posedge gatedPulse or posedge rst) begin
    if (rst) begin
      divQ <= 1'b0;
    end else begin
      divQ <= ~divQ;
    end
  end

  assign divClk   = divQ;
  assign pulseDbg = gatedPulse;

endmodule

// File: rtl/halfphase_divider.sv
`timescale 1ns/1ps
module halfphase_divider
  import hpd_pkg::*;
(
  input  logic clkIn,
  input  logic rst,
  output logic divClk,
  output logic pulseDbg
);

  gateStrobe_t strobe;
  seqVec_t     seqState;
  logic        seqRun;

  hpd_ctrl u_ctrl (
    .clkIn    (clkIn),
    .rst      (rst),
    .strobe   (strobe),
    .seqState (seqState),
    .seqRun   (seqRun)
  );

  hpd_datapath u_datapath (
    .clkIn    (clkIn),
    .rst      (rst),
    .strobe   (strobe),
    .divClk   (divClk),
    .pulseDbg (pulseDbg)
  );

endmodule

// File: rtl/hpd_checker.sv
`timescale 1ns/1ps
module hpd_checker
  import hpd_pkg::*;
(
  input logic    clkIn,
  input logic    rst,
  input logic    divClk,
  input logic    pulseDbg,
  input seqVec_t seqState,
  input logic    seqRun
);

  logic divAtPos;
  logic divAtNeg;

  always_ff @(posedge clkIn) divAtPos <= divClk;
  always_ff @(negedge clkIn) divAtNeg <= divClk;

  AST_ONE_HOT: assert property (@(posedge clkIn) disable iff (rst)
    $onehot(seqState)); // R2

  AST_ADVANCE: assert property (@(posedge clkIn) disable iff (rst)
    seqRun |=> seqState == {$past(seqState[SEQ_LEN-2:0]), $past(seqState[SEQ_LEN-1])}); // R2

  AST_HIGH_SLOTS: assert property (@(negedge clkIn) disable iff (rst)
    pulseDbg == (seqRun && (seqState[0] || seqState[7]))); // R3

  AST_LOW_SLOTS: assert property (@(posedge clkIn) disable iff (rst)
    pulseDbg == seqState[3]); // R3

  AST_TOGGLE_HIGH: assert property (@(negedge clkIn) disable iff (rst)
    seqRun |-> ((divClk != divAtPos) == pulseDbg)); // R5

  AST_TOGGLE_LOW: assert property (@(posedge clkIn) disable iff (rst)
    seqRun |-> ((divClk != divAtNeg) == pulseDbg)); // R5

  AST_RESET_CLEAR: assert property (@(negedge clkIn)
    rst |-> !divClk); // R6

endmodule

bind halfphase_divider hpd_checker u_chk (
  .clkIn    (clkIn),
  .rst      (rst),
  .divClk   (divClk),
  .pulseDbg (pulseDbg),
  .seqState (seqState),
  .seqRun   (seqRun)
);

// File: tb/halfphase_divider_bench.sv
`timescale 1ns/1ps
module halfphase_divider_bench;

  logic clkIn = 1'b0;
  logic rst   = 1'b0;
  logic divClk;
  logic pulseDbg;

  int total = 0;
  int bad   = 0;

  halfphase_divider u_halfphase_divider (
    .clkIn    (clkIn),
    .rst      (rst),
    .divClk   (divClk),
    .pulseDbg (pulseDbg)
  );

  always #5 clkIn = ~clkIn;

  // Expected pulse in slot s: picks at 0, 7, 14 of each 20-slot revolution.
  function automatic logic expPulse(input int s);
    int m;
    m = s % 20;
    return (m == 0) || (m == 7) || (m == 14);
  endfunction

  // Expected output level: parity of pulses in slots 0..s.
  function automatic logic expLevel(input int s);
    int r, m, c;
    r = s / 20;
    m = s % 20;
    c = 3 * r + 1 + int'(m >= 7) + int'(m >= 14);
    return c[0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset(input int n);
    @(posedge clkIn);
    #1 rst = 1'b1;
    #1;
    check(divClk == 1'b0, "R6", "divClk cleared at reset", int'(divClk), 0);
    repeat (n - 1) @(posedge clkIn);
    #2;
    check(divClk == 1'b0, "R6", "divClk during reset", int'(divClk), 0);
    check(pulseDbg == 1'b0, "R6", "pulse during reset", int'(pulseDbg), 0);
    @(posedge clkIn);
    #1 rst = 1'b0;
  endtask

  task automatic runSlots(input int cycles);
    logic lv [80];
    logic pl [80];
    int   lastP;
    int   rises;
    logic prevLv;
    lastP  = -1;
    rises  = 0;
    prevLv = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      for (int h = 0; h < 2; h++) begin
        int s;
        if (h == 0) @(posedge clkIn);
        else        @(negedge clkIn);
        #2;
        s = 2 * c + h;
        if (s == 0) begin
          check(pulseDbg == 1'b1, "R7", "first high phase after release", int'(pulseDbg), 1);
        end else begin
          check(pulseDbg == expPulse(s), "R3", $sformatf("pulse slot %0d", s),
                int'(pulseDbg), int'(expPulse(s)));
        end
        check(divClk == expLevel(s), "R5", $sformatf("level slot %0d", s),
              int'(divClk), int'(expLevel(s)));
        if (pulseDbg) begin
          if (lastP >= 0) begin
            int want;
            want = ((lastP % 20) == 14) ? 6 : 7;
            check((s - lastP) == want, "R4", $sformatf("gap after slot %0d", lastP),
                  s - lastP, want);
          end
          lastP = s;
        end
        if (divClk && !prevLv) rises++;
        prevLv = divClk;
        if (s < 80) begin
          lv[s] = divClk;
          pl[s] = pulseDbg;
          if (s >= 20) begin
            check(pl[s] == pl[s-20], "R2", $sformatf("pulse recurrence slot %0d", s),
                  int'(pl[s]), int'(pl[s-20]));
          end
          if (s >= 40) begin
            check(lv[s] == lv[s-40], "R8", $sformatf("level repeat slot %0d", s),
                  int'(lv[s]), int'(lv[s-40]));
          end
        end
      end
    end
    if ((cycles % 20) == 0) begin
      check(rises == 3 * (cycles / 20), "R1", $sformatf("rising edges in %0d cycles", cycles),
            rises, 3 * (cycles / 20));
    end
  endtask

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd20517);
    #1 rst = 1'b1;
    // reset state before any release
    repeat (2) @(posedge clkIn);
    #2;
    check(divClk == 1'b0, "R6", "initial divClk", int'(divClk), 0);
    check(pulseDbg == 1'b0, "R6", "initial pulse", int'(pulseDbg), 0);
    // directed: full two-revolution-pair run
    doReset(3);
    runSlots(40);
    // directed: cut mid-revolution, then restart must begin at slot 0 (R7)
    doReset(2);
    runSlots(7);
    doReset(2);
    runSlots(20);
    // random mix of truncated and full runs
    for (int i = 0; i < 10; i++) begin
      int k;
      doReset(2 + int'($urandom % 4));
      k = int'($urandom % 3);
      if (k == 0) runSlots(1 + int'($urandom % 19));
      else        runSlots(20 * k);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule